// File: doc/BRIEF.md
# Start-up and Reference Ramp Sequencer

This block owns the digital side of a regulator's power-up: it decides when the output reference may move, where it moves to and how quickly, and when the output is declared good. It watches a supply-valid flag and an enable input, turns a 6-bit select code into a target in millivolts, and advances a digital reference one slew increment per microsecond tick. The reference first climbs from zero to a fixed boot level, and only after that level is reached does it follow the select code.

After the enable and supply are both valid, the reference is held at zero for a programmed number of ticks. It then ramps to the boot level, then to the code's voltage. Power-good comes up a programmed number of ticks after the enable, provided the boot level has been reached. Later code changes slew at the same controlled rate. Dropping the enable or the supply-valid flag clears the reference, the flags and every timer on the next clock edge, so the next enable starts the whole sequence again.

Top module: `vref_startup_seq`

## Requirements
- R1: Select codes 0 to 40 give a target of 1500 - 25 x code millivolts (code 0 is 1500 mV, code 16 is 1100 mV, code 40 is 500 mV), and the reference never exceeds 1500 mV.
- R2: Select codes 41 to 63 give a target of 500 mV.
- R3: While reset is low, or while supply_ok or enable is low, ref_mv, target_mv, ramp_busy, boot_done and pwr_good are all zero.
- R4: For the first DELAY_TICKS ticks after the sequence starts, target_mv and ref_mv stay at 0; from then on the target is BOOT_MV (1200 mV) until the reference first equals BOOT_MV, and boot_done rises on the clock edge after that.
- R5: On each clock edge with us_tick high the reference moves toward the target by SLEW_MV, or by the remaining distance if that is smaller, so it never overshoots; with us_tick low it holds.
- R6: Once boot_done is high, target_mv follows the decoded select code, and a code change slews the reference to the new value at the rate of R5.
- R7: pwr_good rises one clock edge after the tick count since the sequence start reaches PG_TICKS (7000 by default) while boot_done is high, and then stays high while the sequence runs.
- R8: On the first clock edge at which enable or supply_ok is low, the reference, the tick count, boot_done and pwr_good are cleared; when both return high the sequence restarts from R4.
- R9: ramp_busy is high exactly when ref_mv differs from target_mv.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply above its power-on threshold |
| enable | input | 1 | Regulator enable |
| vsel | input | 6 | Voltage select code |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| ref_mv | output | 11 | Present reference in millivolts |
| target_mv | output | 11 | Value the reference is moving toward |
| ramp_busy | output | 1 | Reference differs from target |
| boot_done | output | 1 | Boot level has been reached |
| pwr_good | output | 1 | Output declared good |

## Verification
A wrong tick count shows up at the ports within one tick. It either holds the reference at zero too long or releases it early, and it moves the power-good edge; both are compared against a behavioural model on every clock. A corrupted reference or step shows as a ref_mv mismatch on the same edge. A boot flag that sets early or never sets changes target_mv at once. Odd remainders between 25 mV steps and the 2 mV slew make any overshoot visible as a final value off by one.

// File: rtl/vrs_pkg.sv
// Package: shared widths and types for the reference sequencer.
// Assumes all voltages are whole millivolts below 2048.
package vrs_pkg;
    localparam int MV_W = 11;
    typedef logic [MV_W-1:0] mv_t;
endpackage

// File: rtl/vsel_decode.sv
// Module: maps the select code to a millivolt target.
// Codes above LAST_CODE saturate at the lowest voltage. Purely combinational.
module vsel_decode
    import vrs_pkg::*;
#(
    parameter int CODE_W    = 6,
    parameter int TOP_MV    = 1500,
    parameter int STEP_MV   = 25,
    parameter int LAST_CODE = 40
) (
    input  logic [CODE_W-1:0] code,
    output mv_t               mv
);
    localparam int FLOOR_MV = TOP_MV - STEP_MV * LAST_CODE;

    // Decode: linear descent from TOP_MV, clamped at the floor
    always_comb begin
        if (int'(code) > LAST_CODE) mv = mv_t'(FLOOR_MV);
        else                        mv = mv_t'(TOP_MV - STEP_MV * int'(code));
    end

    // R1/R2: decoded value must stay inside the legal window
    always_comb begin
        assert_decode_window_R2: assert (int'(mv) >= FLOOR_MV && int'(mv) <= TOP_MV)
            else $error("decoded target out of range");
    end
endmodule

// File: rtl/tick_timer.sv
// Module: counts ticks since the sequence started, saturating at PG_TICKS.
// Assumes PG_TICKS > DELAY_TICKS; clear restarts the count.
module tick_timer #(
    parameter int DELAY_TICKS = 100,
    parameter int PG_TICKS    = 7000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic delay_done,
    output logic pg_window
);
    localparam int CW = $clog2(PG_TICKS + 1);

    logic [CW-1:0] cnt;

    // Count: advance on each tick until the power-good limit
    always_ff @(posedge clk) begin
        if (!rst_n || clear)                   cnt <= '0;
        else if (tick && cnt != CW'(PG_TICKS)) cnt <= cnt + 1'b1;
    end

    assign delay_done = (cnt >= CW'(DELAY_TICKS));
    assign pg_window  = (cnt == CW'(PG_TICKS));

    // R7: counter never passes its limit
    assert_cnt_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(PG_TICKS));
    // R5: without a tick the count holds
    assert_cnt_tick_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tick) && !$past(clear)) |-> $stable(cnt));
endmodule

// File: rtl/slew_ramp.sv
// Module: moves the reference toward its target by at most SLEW_MV per tick.
// Assumes the target may change at any cycle; the final step is shortened.
module slew_ramp
    import vrs_pkg::*;
#(
    parameter int SLEW_MV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    input  mv_t  target,
    output mv_t  ref_q,
    output logic busy
);
    localparam mv_t SLEW = mv_t'(SLEW_MV);

    mv_t up_gap;
    mv_t dn_gap;

    // Gap: distance to the target in each direction
    always_comb begin
        up_gap = target - ref_q;
        dn_gap = ref_q - target;
    end

    // Step: one slew increment per tick, shortened to land on the target
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ref_q <= '0;
        end else if (tick) begin
            if (ref_q < target)      ref_q <= (up_gap > SLEW) ? ref_q + SLEW : target;
            else if (ref_q > target) ref_q <= (dn_gap > SLEW) ? ref_q - SLEW : target;
        end
    end

    assign busy = (ref_q != target);

    // R5: no cycle moves the reference further than one slew increment
    assert_step_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clear)) |->
        (((ref_q >= $past(ref_q)) ? (ref_q - $past(ref_q)) : ($past(ref_q) - ref_q)) <= SLEW));
    // R5: the reference only moves on a tick
    assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tick) && !$past(clear)) |-> $stable(ref_q));
endmodule

// File: rtl/vref_startup_seq.sv
// Module: top of the start-up and reference ramp sequencer.
// Holds, then ramps to BOOT_MV, then tracks the select code; raises power-good
// after PG_TICKS. Assumes us_tick is a one-cycle pulse; synchronous reset.
module vref_startup_seq
    import vrs_pkg::*;
#(
    parameter int CODE_W      = 6,
    parameter int TOP_MV      = 1500,
    parameter int STEP_MV     = 25,
    parameter int LAST_CODE   = 40,
    parameter int BOOT_MV     = 1200,
    parameter int SLEW_MV     = 2,
    parameter int DELAY_TICKS = 100,
    parameter int PG_TICKS    = 7000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              enable,
    input  logic [CODE_W-1:0] vsel,
    input  logic              us_tick,
    output logic [MV_W-1:0]   ref_mv,
    output logic [MV_W-1:0]   target_mv,
    output logic              ramp_busy,
    output logic              boot_done,
    output logic              pwr_good
);
    localparam mv_t BOOT = mv_t'(BOOT_MV);

    logic clear;
    logic delay_done;
    logic pg_window;
    mv_t  code_mv;
    mv_t  target;
    mv_t  ref_q;
    logic booted;
    logic pg_q;

    assign clear = !(supply_ok && enable);

    vsel_decode #(
        .CODE_W(CODE_W), .TOP_MV(TOP_MV), .STEP_MV(STEP_MV), .LAST_CODE(LAST_CODE)
    ) u_decode (
        .code(vsel), .mv(code_mv)
    );

    tick_timer #(
        .DELAY_TICKS(DELAY_TICKS), .PG_TICKS(PG_TICKS)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(clear), .tick(us_tick),
        .delay_done(delay_done), .pg_window(pg_window)
    );

    // Target: zero during the delay, boot level until reached, then the code
    always_comb begin
        if (booted)          target = code_mv;
        else if (delay_done) target = BOOT;
        else                 target = '0;
    end

    slew_ramp #(
        .SLEW_MV(SLEW_MV)
    ) u_ramp (
        .clk(clk), .rst_n(rst_n), .clear(clear), .tick(us_tick),
        .target(target), .ref_q(ref_q), .busy(ramp_busy)
    );

    // Sequence flags: boot reached, then power-good at the tick limit
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            booted <= 1'b0;
            pg_q   <= 1'b0;
        end else begin
            if (!booted && delay_done && ref_q == BOOT) booted <= 1'b1;
            pg_q <= booted && pg_window;
        end
    end

    assign ref_mv    = ref_q;
    assign target_mv = target;
    assign boot_done = booted;
    assign pwr_good  = pg_q;

    // R7: power-good never precedes the boot level
    assert_pg_after_boot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_good |-> boot_done);
    // R8: a dropped enable or supply clears everything on the next edge
    assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clear)) |-> (ref_mv == '0 && !boot_done && !pwr_good));
    // R4: before boot completes the reference stays at or below the boot level
    assert_boot_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_done |-> (ref_mv <= BOOT));
    // R1: the reference never exceeds the top of the code range
    assert_ref_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ref_mv <= mv_t'(TOP_MV));
endmodule

// File: tb/test_vref_startup_seq.sv
module test_vref_startup_seq;
    localparam int BOOT = 1200;
    localparam int SLEW = 2;
    localparam int DLY  = 100;
    localparam int PGT  = 7000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        supply_ok = 1'b0;
    logic        enable = 1'b0;
    logic [5:0]  vsel = '0;
    logic        us_tick = 1'b0;
    logic [10:0] ref_mv;
    logic [10:0] target_mv;
    logic        ramp_busy;
    logic        boot_done;
    logic        pwr_good;

    int checks = 0;
    int errors = 0;

    // reference model state
    int m_cnt = 0;
    int m_ref = 0;
    int m_boot = 0;
    int m_pg = 0;

    always #5 clk = ~clk;

    vref_startup_seq i_vref_startup_seq (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .enable(enable),
        .vsel(vsel), .us_tick(us_tick), .ref_mv(ref_mv), .target_mv(target_mv),
        .ramp_busy(ramp_busy), .boot_done(boot_done), .pwr_good(pwr_good)
    );

    function automatic int code_mv(input int c);
        if (c > 40) return 500;
        return 1500 - 25 * c;
    endfunction

    function automatic int model_target();
        if (m_boot != 0) return code_mv(int'(vsel));
        if (m_cnt >= DLY) return BOOT;
        return 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
        end
    endtask

    // model update on each edge, then compare all outputs
    always @(posedge clk) begin
        int tgt, nb, npg;
        if (!rst_n || !(supply_ok && enable)) begin
            m_cnt = 0; m_ref = 0; m_boot = 0; m_pg = 0;
        end else begin
            tgt = model_target();
            nb  = (m_boot == 0 && m_cnt >= DLY && m_ref == BOOT) ? 1 : 0;
            npg = (m_boot != 0 && m_cnt == PGT) ? 1 : 0;
            if (us_tick) begin
                if (m_ref < tgt)      m_ref = (tgt - m_ref > SLEW) ? m_ref + SLEW : tgt;
                else if (m_ref > tgt) m_ref = (m_ref - tgt > SLEW) ? m_ref - SLEW : tgt;
                if (m_cnt < PGT) m_cnt++;
            end
            if (nb != 0) m_boot = 1;
            m_pg = npg;
        end
        #2;
        chk("R5 ref_mv", int'(ref_mv), m_ref);
        chk("R6 target_mv", int'(target_mv), model_target());
        chk("R9 ramp_busy", int'(ramp_busy), (m_ref != model_target()) ? 1 : 0);
        chk("R4 boot_done", int'(boot_done), m_boot);
        chk("R7 pwr_good", int'(pwr_good), m_pg);
    end

    task automatic run(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            us_tick = (gap <= 1) ? 1'b1 : ((i % gap) == 0);
        end
        @(negedge clk);
        us_tick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        enable = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 reset ref", int'(ref_mv), 0);
        chk("R3 reset pg", int'(pwr_good), 0);
        rst_n = 1'b1;
        // supply not valid: sequence stays idle
        run(20, 1);
        chk("R3 no supply ref", int'(ref_mv), 0);
        chk("R3 no supply boot", int'(boot_done), 0);
        // start, code 16 = 1100 mV
        vsel = 6'd16;
        supply_ok = 1'b1;
        run(50, 1);
        chk("R4 held during delay", int'(ref_mv), 0);
        chk("R4 target during delay", int'(target_mv), 0);
        run(100, 1);
        chk("R4 ramp toward boot", int'(ref_mv), 100);
        chk("R9 busy while ramping", int'(ramp_busy), 1);
        chk("R4 boot target", int'(target_mv), BOOT);
        run(6950, 1);
        chk("R6 settled at code 16", int'(ref_mv), 1100);
        chk("R7 power good", int'(pwr_good), 1);
        chk("R9 idle when settled", int'(ramp_busy), 0);
        // code changes slew at the same rate
        vsel = 6'd0;
        run(600, 1);
        chk("R1 code 0 is 1500", int'(ref_mv), 1500);
        vsel = 6'd63;
        run(600, 1);
        chk("R2 code 63 clamps 500", int'(ref_mv), 500);
        vsel = 6'd40;
        run(10, 1);
        chk("R1 code 40 is 500", int'(target_mv), 500);
        vsel = 6'd1;
        run(1500, 3);
        chk("R5 sparse ticks reach 1475", int'(ref_mv), 1475);
        // enable drop mid ramp
        vsel = 6'd0;
        run(5, 1);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R8 enable drop ref", int'(ref_mv), 0);
        chk("R8 enable drop pg", int'(pwr_good), 0);
        chk("R8 enable drop boot", int'(boot_done), 0);
        // restart with code 12 = 1200, ticks every second cycle
        vsel = 6'd12;
        enable = 1'b1;
        run(15000, 2);
        chk("R6 code equal to boot", int'(ref_mv), 1200);
        chk("R7 pg after restart", int'(pwr_good), 1);
        // supply drop
        @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        chk("R8 supply drop ref", int'(ref_mv), 0);
        chk("R3 supply drop target", int'(target_mv), 0);
        run(5, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule